// File: doc/BRIEF.md
# Bitmask Immediate Expander

This block turns a 13-bit packed bitmask immediate into the constant it stands for. The packed form has a one-bit wide-element flag, a 6-bit size/length field and a 6-bit rotate field. A separate width select chooses between a 64-bit and a 32-bit destination. The element size comes from the flag together with the position of the highest clear bit of the size/length field. Inside one element the low S+1 bits are set. That element is rotated right by R and then tiled across the destination. Encodings that name no valid pattern raise an illegal flag and return zero.

Requests enter through a valid/ready handshake and results leave through another. With the default parameter the result is held in one output register. A request is accepted when `in_valid` and `in_ready` are both high at a clock edge, and its result appears on the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds its value and no new request is taken. With `REG_OUT = 0` the path is purely combinational and the handshake passes straight through.

Top module: `bmi_expand`

## Requirements
- R1: With the wide-element flag set (`in_n` = 1), the element is 64 bits wide, S is all six bits of `in_imms` and R is all six bits of `in_immr`.
- R2: With `in_n` = 0, the element size is set by the highest clear bit b of `in_imms`: b=5 gives 32, b=4 gives 16, b=3 gives 8, b=2 gives 4 and b=1 gives 2. S is then `in_imms[b-1:0]`.
- R3: R is `in_immr[b-1:0]` (all six bits when `in_n` = 1). The rotate bits above that range do not change the result.
- R4: The element has its low S+1 bits set and the rest clear, and is rotated right by R places within the element.
- R5: The rotated element is repeated from bit 0 upward to fill 64 bits when `in_wide` = 1, or 32 bits when `in_wide` = 0.
- R6: If the S bits in use are all ones, the encoding is illegal. An illegal result has `out_illegal` = 1 and `out_value` = 0.
- R7: Two further cases are illegal. One is `in_n` = 1 with `in_wide` = 0. The other is `in_n` = 0 with `in_imms` = 11111x (no clear bit above bit 0).
- R8: When `in_wide` = 0, `out_value[63:32]` is zero.
- R9: The request accepted at an edge (`in_valid && in_ready`) produces `out_valid` on the next cycle. `in_ready` = !`out_valid` || `out_ready`. While `out_valid && !out_ready`, `out_value` and `out_illegal` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_n | input | 1 | Wide-element flag |
| in_imms | input | 6 | Size prefix and run length field |
| in_immr | input | 6 | Rotate field |
| in_wide | input | 1 | 1 = 64-bit destination, 0 = 32-bit |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_value | output | 64 | Expanded constant |
| out_illegal | output | 1 | Encoding is reserved |

## Verification
Some properties are checked on every cycle by assertions:
- an illegal result carries a zero value;
- a 32-bit result has a clear upper half;
- a wide-element request on a 32-bit destination always comes out illegal;
- at most one element size is selected at a time;
- a stalled output stays frozen.

Only the bench's scenarios can show that the pattern itself is right. That covers the size prefix decode, the run length, the rotation and the tiling. The bench sweeps every flag, size/length and rotate combination in both widths and compares each result with an arithmetic model. The one-cycle latency and the hold under back-pressure are also shown by a directed stall scenario.

// File: rtl/bmi_pkg.sv
package bmi_pkg;
  localparam int FIELD_W   = 6;
  localparam int DATA_W    = 64;
  localparam int HALF_W    = DATA_W / 2;
  localparam int NUM_SIZES = FIELD_W;
  localparam int LG_W      = $clog2(FIELD_W + 1);

  typedef struct packed {
    logic [FIELD_W-1:0] s;
    logic [FIELD_W-1:0] r;
    logic [LG_W-1:0]    lg;
    logic               ill;
  } bmi_dec_t;
endpackage

// File: rtl/bmi_size_decode.sv
module bmi_size_decode
  import bmi_pkg::*;
(
  input  logic                 n,
  input  logic [FIELD_W-1:0]   imms,
  input  logic [FIELD_W-1:0]   immr,
  input  logic                 wide,
  output bmi_dec_t             dec,
  output logic [NUM_SIZES-1:0] size_sel
);
  logic [LG_W-1:0]    lg;
  logic [FIELD_W-1:0] levels;
  logic [FIELD_W-1:0] s_used;

  // Element size: highest clear bit of imms, or the full width when n is set.
  always_comb begin
    lg = '0;
    for (int b = 0; b < FIELD_W; b++) begin
      if (!imms[b]) lg = LG_W'(b);
    end
    if (n) lg = LG_W'(FIELD_W);
  end

  always_comb begin
    for (int b = 0; b < FIELD_W; b++) begin
      levels[b] = (LG_W'(b) < lg);
    end
  end

  assign s_used  = imms & levels;
  assign dec.s   = s_used;
  assign dec.r   = immr & levels;
  assign dec.lg  = lg;
  assign dec.ill = (lg == '0) || (s_used == levels) || (n && !wide);

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_sel
    assign size_sel[k] = !dec.ill && (lg == LG_W'(k + 1));
  end
endmodule

// File: rtl/bmi_tile.sv
module bmi_tile
  import bmi_pkg::*;
#(
  parameter int LG = 1
) (
  input  logic [FIELD_W-1:0] s,
  input  logic [FIELD_W-1:0] r,
  output logic [DATA_W-1:0]  pattern
);
  localparam int ES = 1 << LG;

  logic [ES-1:0] elem;
  logic [ES-1:0] rot;

  // Low S+1 bits set.
  always_comb begin
    for (int i = 0; i < ES; i++) begin
      elem[i] = (i <= int'(s));
    end
  end

  // Rotate right by R within the element.
  always_comb begin
    for (int i = 0; i < ES; i++) begin
      rot[i] = elem[(i + int'(r)) % ES];
    end
  end

  // Tile across the full data width.
  always_comb begin
    for (int j = 0; j < DATA_W; j++) begin
      pattern[j] = rot[j % ES];
    end
  end
endmodule

// File: rtl/bmi_expand.sv
module bmi_expand
  import bmi_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_n,
  input  logic [FIELD_W-1:0] in_imms,
  input  logic [FIELD_W-1:0] in_immr,
  input  logic               in_wide,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_value,
  output logic               out_illegal
);
  bmi_dec_t             dec;
  logic [NUM_SIZES-1:0] size_sel;
  logic [DATA_W-1:0]    pat [NUM_SIZES];
  logic [DATA_W-1:0]    value_c;

  bmi_size_decode u_dec (
    .n        (in_n),
    .imms     (in_imms),
    .immr     (in_immr),
    .wide     (in_wide),
    .dec      (dec),
    .size_sel (size_sel)
  );

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_tile
    bmi_tile #(.LG(k + 1)) u_tile (
      .s       (dec.s),
      .r       (dec.r),
      .pattern (pat[k])
    );
  end

  always_comb begin
    value_c = '0;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (size_sel[k]) value_c = pat[k];
    end
    if (!in_wide) value_c[DATA_W-1:HALF_W] = '0;
  end

  if (REG_OUT) begin : g_reg
    logic              vld_q;
    logic              ill_q;
    logic              wide_q;
    logic [DATA_W-1:0] val_q;
    logic              accept;

    assign accept = in_valid && in_ready;
    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        ill_q  <= 1'b0;
        wide_q <= 1'b1;
        val_q  <= '0;
      end else if (accept) begin
        vld_q  <= 1'b1;
        ill_q  <= dec.ill;
        wide_q <= in_wide;
        val_q  <= value_c;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end

    assign out_valid   = vld_q;
    assign out_value   = val_q;
    assign out_illegal = ill_q;

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !out_ready) |=> (vld_q && $stable(val_q) && $stable(ill_q)));
    assert_illegal_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && ill_q) |-> (val_q == '0));
    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !wide_q) |-> (val_q[DATA_W-1:HALF_W] == '0));
    assert_narrow_wide_elem_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_n && !in_wide) |=> ill_q);
    assert_one_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(size_sel));
  end else begin : g_comb
    assign in_ready    = out_ready;
    assign out_valid   = in_valid;
    assign out_value   = value_c;
    assign out_illegal = dec.ill;
  end
endmodule

// File: tb/bmi_expand_tb.sv
module bmi_expand_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_n = 1'b0;
  logic [5:0]  in_imms = '0;
  logic [5:0]  in_immr = '0;
  logic        in_wide = 1'b1;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_value;
  logic        out_illegal;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bmi_expand u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_n(in_n), .in_imms(in_imms), .in_immr(in_immr), .in_wide(in_wide),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_value(out_value), .out_illegal(out_illegal)
  );

  function automatic void model(input bit w, input bit n, input logic [5:0] s6,
                                input logic [5:0] r6, output logic [63:0] v,
                                output bit ill);
    int len, esize, smask, sv, rv;
    logic [63:0] elem, emask, rot;
    len = 0;
    for (int b = 0; b < 6; b++) if (!s6[b]) len = b;
    if (n) len = 6;
    v = '0;
    ill = (len < 1) || (n && !w);
    if (!ill) begin
      esize = 1 << len;
      smask = esize - 1;
      sv = int'(s6) & smask;
      rv = int'(r6) & smask;
      if (sv == smask) ill = 1'b1;
      else begin
        emask = (esize == 64) ? ~64'd0 : ((64'd1 << esize) - 64'd1);
        elem = (64'd1 << (sv + 1)) - 64'd1;
        if (rv == 0) rot = elem;
        else rot = ((elem >> rv) | (elem << (esize - rv))) & emask;
        for (int p = 0; p < 64; p += esize) v = v | (rot << p);
        if (!w) v[63:32] = '0;
      end
    end
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input bit w, input bit n, input logic [5:0] s6,
                       input logic [5:0] r6, input string tag);
    logic [63:0] ev;
    bit eill;
    model(w, n, s6, r6, ev, eill);
    @(negedge clk);
    in_valid = 1'b1; in_wide = w; in_n = n; in_imms = s6; in_immr = r6;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R9 valid", 64'(out_valid), 64'd1);
    check(out_illegal == eill, eill ? "R6 R7 illegal flag" : "R6 legal flag",
          64'(out_illegal), 64'(eill));
    check(out_value == ev, tag, out_value, ev);
  endtask

  initial begin
    logic [63:0] ea, eb;
    bit ia, ib;
    #4;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R9 reset valid", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R9 reset ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    // Directed corner cases
    apply(1'b1, 1'b1, 6'd0, 6'd0, "R1 single bit");
    apply(1'b1, 1'b1, 6'd62, 6'd1, "R1 R4 rotated run");
    apply(1'b1, 1'b1, 6'd63, 6'd0, "R6 all ones 64");
    apply(1'b0, 1'b1, 6'd3, 6'd0, "R7 wide elem narrow dest");
    apply(1'b1, 1'b0, 6'b111110, 6'd0, "R7 prefix 11111x");
    apply(1'b1, 1'b0, 6'b111100, 6'd1, "R2 R5 size two");
    apply(1'b0, 1'b0, 6'b000011, 6'b111101, "R3 upper rotate ignored");
    apply(1'b0, 1'b0, 6'b011111, 6'd0, "R6 all ones 32");
    apply(1'b0, 1'b0, 6'b110001, 6'd3, "R8 narrow upper zero");

    // Exhaustive sweep
    for (int w = 0; w < 2; w++)
      for (int n = 0; n < 2; n++)
        for (int s = 0; s < 64; s++)
          for (int r = 0; r < 64; r++)
            apply(w[0], n[0], s[5:0], r[5:0],
                  n[0] ? (w[0] ? "R1 R3 R4 R5 sweep" : "R7 sweep")
                       : (w[0] ? "R2 R3 R4 R5 sweep" : "R2 R5 R8 sweep"));

    // Back-pressure
    model(1'b1, 1'b0, 6'b100011, 6'd2, ea, ia);
    model(1'b1, 1'b0, 6'b000000, 6'd5, eb, ib);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_wide = 1'b1; in_n = 1'b0; in_imms = 6'b100011; in_immr = 6'd2;
    @(negedge clk);
    check(in_ready == 1'b0, "R9 stall ready", 64'(in_ready), 64'd0);
    check(out_value == ea, "R9 first result", out_value, ea);
    in_imms = 6'b000000; in_immr = 6'd5;
    @(negedge clk);
    check(out_valid == 1'b1 && out_value == ea, "R9 held under stall", out_value, ea);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1 && out_value == eb, "R9 second after release", out_value, eb);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 drained", 64'(out_valid), 64'd0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule